// File: doc/BRIEF.md
# Serial Control Word Loader with PA Ramp Sequencer

This block takes a control word over a three-wire serial link: a serial clock, a data line and a load line. Each rising edge of the serial clock shifts one data bit into a holding shift register, most significant bit first. The serial clock and load line come from outside the chip, so all three wires are resampled by a two-stage synchronizer into the system clock domain. When the load line changes level in either direction while the serial clock is high, an internal load pulse copies the holding register into the active control register. The radio then follows the new word at once. While the load line stays quiet during serial-clock-high phases, the next word can be shifted in with no effect on the active one.

The block also sequences the power-amplifier enable. When a transmit word becomes active, the amplifier ramp waits for three things: a falling edge of the serial clock after the load, at least one comparison-reference tick after the load, and an asserted PLL lock indication. The ramp then climbs one step per comparison tick, and the enable output is set only on the top step. A load request that arrives while the amplifier is ramping or fully on first ramps the amplifier down to zero, and only then issues the load pulse.

Top module: `serial_ctrl_loader`

## Requirements
- R1: After reset, ctrlWord, loadPulse, paEn, rampLevel and tmgViol are all zero.
- R2: Data is sampled on each rising edge of serClk. After WORD_W rising edges, the holding register contains the last WORD_W bits, with the first bit sent in the most significant position.
- R3: A change of loadLine in either direction while serClk is high raises loadPulse for exactly one clk cycle, three clk edges after the loadLine change when the amplifier is off. ctrlWord takes the holding register value on the next edge.
- R4: A loadLine change while serClk is low produces no loadPulse and leaves ctrlWord unchanged. Shifting new bits does not change ctrlWord.
- R5: A word whose two most significant bits are 2'b10 selects transmit. Any other code never moves rampLevel off zero.
- R6: After a transmit load, the ramp starts only when three conditions hold: a serClk falling edge has been seen, a cmpTick has arrived after the load pulse, and lockDet is high. With lockDet low, rampLevel stays at zero.
- R7: During ramp-up, rampLevel rises by one on each cmpTick up to RAMP_STEPS. paEn is high only when rampLevel equals RAMP_STEPS.
- R8: A serClk falling edge that arrives after a transmit load but before any cmpTick raises tmgViol for one cycle. The ramp start is then held back until a cmpTick has arrived.
- R9: A load request while the amplifier is ramping up or fully on lowers rampLevel by one per cmpTick. loadPulse is issued one cycle after rampLevel reaches zero, never earlier, and ctrlWord then takes the newly shifted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial shift clock, asynchronous |
| loadLine | input | 1 | Load request line, either edge, asynchronous |
| serData | input | 1 | Serial data bit |
| lockDet | input | 1 | PLL lock indication, synchronous to clk |
| cmpTick | input | 1 | One-cycle comparison-reference tick |
| ctrlWord | output | WORD_W | Active control register |
| loadPulse | output | 1 | Internal load pulse |
| paEn | output | 1 | Power-amplifier full enable |
| rampLevel | output | RAMP_W | Current amplifier ramp step |
| tmgViol | output | 1 | One-cycle flag for an early serClk fall |

## Verification
With the amplifier off, a loadLine change reaches loadPulse after three clk edges, two in the synchronizer and one in the sequencer. ctrlWord is due one edge after that. The bench samples at the falling clk edge of each of those exact cycles and checks that loadPulse is low the cycle before and the cycle after. A serClk fall is flagged on tmgViol two edges after it is driven. Each cmpTick moves rampLevel on the edge that samples it, so rampLevel is read on the falling edge that follows each tick. After ramp-down, the load pulse is expected exactly one cycle after rampLevel reaches zero.

// File: rtl/slc_pkg.sv
package slc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_ARM,
    S_RAMPUP,
    S_FULL,
    S_RAMPDN
  } seq_state_e;

  typedef struct packed {
    logic capWord;
    logic loadNow;
    logic clrMin;
    logic rampUp;
    logic rampDn;
  } ctrl_strobe_t;

endpackage

// File: rtl/slc_sync.sv
module slc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[g] <= '0;
      else       chain[g] <= chain[g-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/slc_datapath.sv
module slc_datapath
  import slc_pkg::*;
#(
  parameter int          WORD_W     = 8,
  parameter int          RAMP_STEPS = 4,
  parameter logic [1:0]  TX_CODE    = 2'b10,
  localparam int         RAMP_W     = $clog2(RAMP_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClkRaw,
  input  logic              loadLineRaw,
  input  logic              serDataRaw,
  input  logic              cmpTick,
  input  ctrl_strobe_t      strb,
  output logic              toggleHi,
  output logic              clkFall,
  output logic              minMet,
  output logic              pendTx,
  output logic              rampTop,
  output logic              rampZero,
  output logic [WORD_W-1:0] ctrlReg,
  output logic [RAMP_W-1:0] rampLevel
);

  localparam logic [RAMP_W-1:0] RAMP_LAST = RAMP_W'(RAMP_STEPS);

  logic [2:0]        syncd;
  logic              clkS, loadS, dataS;
  logic              clkPrev, loadPrev;
  logic              clkRise;
  logic [WORD_W-1:0] shiftReg, pendWord;

  slc_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({serClkRaw, loadLineRaw, serDataRaw}),
    .dout (syncd)
  );

  assign {clkS, loadS, dataS} = syncd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      loadPrev <= 1'b0;
    end else begin
      clkPrev  <= clkS;
      loadPrev <= loadS;
    end
  end

  assign clkRise  = clkS & ~clkPrev;
  assign clkFall  = ~clkS & clkPrev;
  assign toggleHi = (loadS ^ loadPrev) & clkS;

  // serial shift, first bit ends in the MSB
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        shiftReg <= '0;
    else if (clkRise) shiftReg <= {shiftReg[WORD_W-2:0], dataS};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pendWord <= '0;
    else if (strb.capWord) pendWord <= shiftReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ctrlReg <= '0;
    else if (strb.loadNow) ctrlReg <= pendWord;
  end

  assign pendTx = (pendWord[WORD_W-1 -: 2] == TX_CODE);

  // minimum time after load: one comparison tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            minMet <= 1'b0;
    else if (strb.clrMin) minMet <= 1'b0;
    else if (cmpTick)     minMet <= 1'b1;
  end

  assign rampTop  = (rampLevel == RAMP_LAST);
  assign rampZero = (rampLevel == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rampLevel <= '0;
    else if (cmpTick && strb.rampUp && !rampTop)
      rampLevel <= rampLevel + 1'b1;
    else if (cmpTick && strb.rampDn && !rampZero)
      rampLevel <= rampLevel - 1'b1;
  end

  // R7: the ramp only moves on a comparison tick
  a_r7_step_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (rampLevel != $past(rampLevel)) |-> $past(cmpTick));

  // R4: the active word holds unless a load strobe was issued
  a_r4_word_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadNow |=> $stable(ctrlReg));

endmodule

// File: rtl/slc_control.sv
module slc_control
  import slc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         toggleHi,
  input  logic         clkFall,
  input  logic         minMet,
  input  logic         pendTx,
  input  logic         rampTop,
  input  logic         rampZero,
  input  logic         lockDet,
  output ctrl_strobe_t strb,
  output logic         tmgViol
);

  seq_state_e st, nxt;
  logic       fallSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       fallSeen <= 1'b0;
    else if (st == S_LOAD)           fallSeen <= 1'b0;
    else if (st == S_ARM && clkFall) fallSeen <= 1'b1;
  end

  always_comb begin
    nxt     = st;
    strb    = '0;
    tmgViol = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (toggleHi) begin
          strb.capWord = 1'b1;
          nxt          = S_LOAD;
        end
      end
      S_LOAD: begin
        strb.loadNow = 1'b1;
        strb.clrMin  = 1'b1;
        nxt          = pendTx ? S_ARM : S_IDLE;
      end
      S_ARM: begin
        tmgViol = clkFall && !minMet;
        if (toggleHi) begin
          strb.capWord = 1'b1;
          nxt          = S_LOAD;
        end else if ((fallSeen || clkFall) && minMet && lockDet) begin
          nxt = S_RAMPUP;
        end
      end
      S_RAMPUP: begin
        strb.rampUp = 1'b1;
        if (toggleHi) begin
          strb.capWord = 1'b1;
          nxt          = S_RAMPDN;
        end else if (rampTop) begin
          nxt = S_FULL;
        end
      end
      S_FULL: begin
        if (toggleHi) begin
          strb.capWord = 1'b1;
          nxt          = S_RAMPDN;
        end
      end
      S_RAMPDN: begin
        strb.rampDn = 1'b1;
        if (rampZero) nxt = S_LOAD;
      end
      default: nxt = S_IDLE;
    endcase
  end

  // R6: ramp-up is entered only with lock and a seen serial-clock fall
  a_r6_lock_before_ramp: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_RAMPUP && $past(st) == S_ARM) |-> ($past(lockDet) && $past(fallSeen || clkFall)));

  // R9: a load is never issued while the amplifier is above zero
  a_r9_load_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadNow |-> rampZero);

  // R8: the violation flag never fires once the minimum time is met
  a_r8_flag_only_early: assert property (@(posedge clk) disable iff (!rstN)
    tmgViol |-> !minMet);

endmodule

// File: rtl/serial_ctrl_loader.sv
module serial_ctrl_loader
  import slc_pkg::*;
#(
  parameter int         WORD_W     = 8,
  parameter int         RAMP_STEPS = 4,
  parameter logic [1:0] TX_CODE    = 2'b10,
  localparam int        RAMP_W     = $clog2(RAMP_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              loadLine,
  input  logic              serData,
  input  logic              lockDet,
  input  logic              cmpTick,
  output logic [WORD_W-1:0] ctrlWord,
  output logic              loadPulse,
  output logic              paEn,
  output logic [RAMP_W-1:0] rampLevel,
  output logic              tmgViol
);

  ctrl_strobe_t strb;
  logic toggleHi, clkFall, minMet, pendTx, rampTop, rampZero;

  slc_datapath #(
    .WORD_W     (WORD_W),
    .RAMP_STEPS (RAMP_STEPS),
    .TX_CODE    (TX_CODE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .serClkRaw   (serClk),
    .loadLineRaw (loadLine),
    .serDataRaw  (serData),
    .cmpTick     (cmpTick),
    .strb        (strb),
    .toggleHi    (toggleHi),
    .clkFall     (clkFall),
    .minMet      (minMet),
    .pendTx      (pendTx),
    .rampTop     (rampTop),
    .rampZero    (rampZero),
    .ctrlReg     (ctrlWord),
    .rampLevel   (rampLevel)
  );

  slc_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .toggleHi (toggleHi),
    .clkFall  (clkFall),
    .minMet   (minMet),
    .pendTx   (pendTx),
    .rampTop  (rampTop),
    .rampZero (rampZero),
    .lockDet  (lockDet),
    .strb     (strb),
    .tmgViol  (tmgViol)
  );

  assign loadPulse = strb.loadNow;
  assign paEn      = rampTop;

  // R7: full enable never coexists with a load pulse
  a_r7_no_load_when_on: assert property (@(posedge clk) disable iff (!rstN)
    paEn |-> !loadPulse);

endmodule

// File: tb/serial_ctrl_loader_bench.sv
module serial_ctrl_loader_bench;

  localparam int WORD_W     = 8;
  localparam int RAMP_STEPS = 4;
  localparam int RAMP_W     = $clog2(RAMP_STEPS + 1);

  logic clk = 1'b0;
  logic rstN, serClk, loadLine, serData, lockDet, cmpTick;
  logic [WORD_W-1:0] ctrlWord;
  logic loadPulse, paEn, tmgViol;
  logic [RAMP_W-1:0] rampLevel;

  int  nChk  = 0;
  int  nFail = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;

  serial_ctrl_loader #(.WORD_W(WORD_W), .RAMP_STEPS(RAMP_STEPS)) u_serial_ctrl_loader (
    .clk (clk), .rstN (rstN), .serClk (serClk), .loadLine (loadLine),
    .serData (serData), .lockDet (lockDet), .cmpTick (cmpTick),
    .ctrlWord (ctrlWord), .loadPulse (loadPulse), .paEn (paEn),
    .rampLevel (rampLevel), .tmgViol (tmgViol)
  );

  // {word, serClk high during the load-line change}
  localparam logic [8:0] VECS [6] = '{
    {8'h3C, 1'b1}, {8'h81, 1'b1}, {8'h5A, 1'b0},
    {8'hFF, 1'b1}, {8'h00, 1'b1}, {8'hC3, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    cmpTick = 1'b1;
    @(negedge clk);
    cmpTick = 1'b0;
  endtask

  task automatic shiftWord(logic [WORD_W-1:0] w);
    for (int i = WORD_W - 1; i >= 0; i--) begin
      serData = w[i];
      serClk  = 1'b0;
      waitN(4);
      serClk  = 1'b1;
      waitN(4);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; serClk = 1'b0; loadLine = 1'b0; serData = 1'b0;
    lockDet = 1'b0; cmpTick = 1'b0;
    waitN(3);
    rstN = 1'b1;
    waitN(2);
  endtask

  task automatic loadAndArm(logic [WORD_W-1:0] w);
    shiftWord(w);
    waitN(4);
    loadLine = ~loadLine;
    waitN(4);
  endtask

  initial begin
    logic [WORD_W-1:0] expWord;
    doReset();
    // R1 reset state
    check("R1 ctrlWord", ctrlWord, 0);
    check("R1 loadPulse", loadPulse, 0);
    check("R1 paEn", paEn, 0);
    check("R1 rampLevel", rampLevel, 0);
    check("R1 tmgViol", tmgViol, 0);

    // table walk: R2 shift order, R3 either-edge load, R4 ignored when serClk low
    expWord = '0;
    for (int v = 0; v < 6; v++) begin
      logic [WORD_W-1:0] w;
      logic hi;
      {w, hi} = VECS[v];
      shiftWord(w);
      check("R4 shift leaves ctrlWord", ctrlWord, expWord);
      if (!hi) begin serClk = 1'b0; waitN(4); end
      loadLine = ~loadLine;
      waitN(2);
      check("R3 no early loadPulse", loadPulse, 0);
      waitN(1);
      check(hi ? "R3 loadPulse due" : "R4 no loadPulse", loadPulse, hi);
      if (hi) expWord = w;
      waitN(1);
      check(hi ? "R2 R3 ctrlWord" : "R4 ctrlWord kept", ctrlWord, expWord);
      check("R3 single-cycle pulse", loadPulse, 0);
      if (!hi) begin waitN(4); check("R4 still no load", ctrlWord, expWord); serClk = 1'b1; end
      waitN(4);
    end

    // R6 R7 R9 normal transmit cycle
    doReset();
    lockDet = 1'b1;
    loadAndArm(8'h9C);
    check("R3 tx word active", ctrlWord, 8'h9C);
    tick();
    serClk = 1'b0;
    waitN(2);
    check("R8 no flag when timely", tmgViol, 0);
    waitN(4);
    for (int k = 1; k <= RAMP_STEPS; k++) begin
      tick();
      check("R7 rampLevel up", rampLevel, k);
      check("R7 paEn top only", paEn, (k == RAMP_STEPS));
    end
    shiftWord(8'h41);
    waitN(4);
    loadLine = ~loadLine;
    waitN(6);
    check("R9 no load while on", loadPulse, 0);
    check("R9 paEn held", paEn, 1);
    check("R9 ctrlWord held", ctrlWord, 8'h9C);
    for (int k = RAMP_STEPS - 1; k >= 0; k--) begin
      tick();
      check("R9 rampLevel down", rampLevel, k);
      check("R9 paEn off", paEn, 0);
      check("R9 load waits", loadPulse, 0);
    end
    waitN(1);
    check("R9 loadPulse after zero", loadPulse, 1);
    waitN(1);
    check("R9 new word", ctrlWord, 8'h41);

    // R6 lock gating
    doReset();
    loadAndArm(8'h9C);
    tick();
    serClk = 1'b0;
    waitN(4);
    tick(); tick();
    check("R6 held without lock", rampLevel, 0);
    lockDet = 1'b1;
    waitN(1);
    tick();
    check("R6 ramp after lock", rampLevel, 1);

    // R8 early serClk fall
    doReset();
    lockDet = 1'b1;
    loadAndArm(8'h9C);
    serClk = 1'b0;
    waitN(1);
    check("R8 flag not yet", tmgViol, 0);
    waitN(1);
    check("R8 flag raised", tmgViol, 1);
    waitN(1);
    check("R8 flag one cycle", tmgViol, 0);
    waitN(5);
    check("R8 ramp delayed", rampLevel, 0);
    tick();
    waitN(2);
    check("R8 no step on min tick", rampLevel, 0);
    tick();
    check("R8 ramp after min", rampLevel, 1);

    // R5 non-transmit word
    doReset();
    lockDet = 1'b1;
    loadAndArm(8'h41);
    tick();
    serClk = 1'b0;
    waitN(4);
    tick(); tick(); tick();
    check("R5 rampLevel stays", rampLevel, 0);
    check("R5 paEn stays", paEn, 0);
    check("R5 word active", ctrlWord, 8'h41);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

endmodule